// File: doc/BRIEF.md
# Shift-and-Add Arithmetic Unit with Shift-Aware Overflow

This unit computes `(A << k) + B`, with an optional carry-in, where `k` is a pre-shift of 0 to 3 bit positions. It works on either 32-bit or 64-bit words. A valid strobe registers each result one clock later. The result includes the sum, a per-bit carry vector, and two overflow flags. The signed flag and the unsigned flag each count bits disturbed by the pre-shift as well as overflow out of the adder. A shift that changes the value's sign, or that drops set bits off the top, is therefore reported even when the add that follows is harmless.

A stored carry flag holds the carry-out at the active sign position of the last result that was written back. It can be fed into bit 0 of the next add, so that wider sums can be chained. When trap-on-overflow is enabled and the operation overflows as a signed add, the unit raises a one-cycle trap pulse. The sum, the carry vector and the stored carry then keep their previous values.

Top module: `shladd_unit`

## Requirements
- R1: In 64-bit mode (`mode64`=1), one cycle after a valid strobe `sum_q` equals `(op_a << shamt) + op_b + cin` modulo 2^64, for `shamt` 0 to 3. Here cin is the stored carry when `use_carry`=1 and 0 otherwise.
- R2: In 32-bit mode (`mode64`=0), only bits 31:0 of both operands are used. The shifted operand is truncated to 32 bits, bits 63:32 of `sum_q` and `cvec_q` are zero, and every flag is taken at sign bit 31.
- R3: Adder signed overflow is set when the shifted first operand and the second operand have equal sign bits and the sum's sign bit differs from them.
- R4: With `shamt`=k≥1, `sv_q` is also set when any of the k bits just below the sign bit of the (masked) original `op_a` differs from that sign bit.
- R5: `uv_q` is the adder carry-out at the sign position, ORed for k≥1 with any set bit among the top k bits of the original operand (sign bit down to sign−k+1). For k=0 it is the carry-out alone.
- R6: `cvec_q` equals the shifted first operand XOR the second operand XOR the sum, all in the active width.
- R7: Each written-back operation loads the stored carry from the carry-out at the active sign position. With `use_carry`=1 that carry is added at bit 0. Reset clears it.
- R8: Outputs change only one cycle after a valid strobe. `trap_q` is high for exactly that one cycle.
- R9: When `trap_en`=1 and signed overflow occurs, `trap_q` pulses and `sum_q`, `cvec_q` and the stored carry keep their old values. `sv_q` and `uv_q` still update.
- R10: Synchronous reset clears `sum_q`, `cvec_q`, `sv_q`, `uv_q`, `trap_q` and the stored carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | Operand that is pre-shifted |
| op_b | input | 64 | Second addend |
| shamt | input | 2 | Pre-shift amount, 0 to 3 |
| mode64 | input | 1 | 1 = 64-bit words, 0 = 32-bit words |
| use_carry | input | 1 | Add the stored carry at bit 0 |
| trap_en | input | 1 | Trap and suppress writeback on signed overflow |
| sum_q | output | 64 | Registered sum |
| sv_q | output | 1 | Registered signed overflow |
| uv_q | output | 1 | Registered unsigned overflow |
| cvec_q | output | 64 | Registered per-bit carry vector |
| trap_q | output | 1 | One-cycle overflow-trap pulse |

## Verification
The bench aims at operands whose pre-shift overflows while the sum happens to land back in range. A design that looks only at the adder would clear `sv_q` on such a case. It also drives set bits sitting just at the top of the word, which a design that drops shift-lost bits would miss in `uv_q`. Operands with garbage in the upper half are run in 32-bit mode, so that a design taking the sign at bit 63 or leaking upper bits into the result shows up. Chained carries and trapped operations are checked to confirm that a trap freezes the sum and the carry, and that a design which writes back regardless gets caught.

// File: rtl/shladd_pkg.sv
package shladd_pkg;
  localparam int XLEN = 64;
  localparam int SHW  = 2;
  typedef enum logic {WORD32 = 1'b0, WORD64 = 1'b1} word_mode_e;
endpackage

// File: rtl/shladd_shift_ovf.sv
module shladd_shift_ovf #(
  parameter int XLEN = 64,
  parameter int SHW  = 2
) (
  input  logic [XLEN-1:0] a_m,
  input  logic [SHW-1:0]  shamt,
  input  logic            mode64,
  output logic [XLEN-1:0] sa,
  output logic            shift_sv,
  output logic            shift_lost
);
  localparam int HALF  = XLEN / 2;
  localparam int MAXSH = (1 << SHW) - 1;

  logic [XLEN-1:0] shifted;
  int              sidx;

  always_comb begin
    shifted = a_m << shamt;
    sa      = mode64 ? shifted : {{HALF{1'b0}}, shifted[HALF-1:0]};
    sidx    = mode64 ? XLEN - 1 : HALF - 1;
    shift_sv   = 1'b0;
    shift_lost = 1'b0;
    for (int i = 1; i <= MAXSH; i++) begin
      if (i <= int'(shamt)) begin
        // bits passing into or through the sign must match it
        shift_sv   = shift_sv | (a_m[sidx - i] ^ a_m[sidx]);
        // bits pushed past the sign position are lost
        shift_lost = shift_lost | a_m[sidx - i + 1];
      end
    end
  end
endmodule

// File: rtl/shladd_adder.sv
module shladd_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] sa,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  input  logic            mode64,
  output logic [XLEN-1:0] sum,
  output logic [XLEN-1:0] cvec,
  output logic            cout,
  output logic            add_sv
);
  localparam int HALF = XLEN / 2;

  logic [XLEN:0] wide;
  logic          s_a, s_b, s_r;

  always_comb begin
    wide = {1'b0, sa} + {1'b0, b} + {{XLEN{1'b0}}, cin};
    if (mode64) begin
      sum  = wide[XLEN-1:0];
      cout = wide[XLEN];
      s_a  = sa[XLEN-1];
      s_b  = b[XLEN-1];
      s_r  = wide[XLEN-1];
    end else begin
      sum  = {{HALF{1'b0}}, wide[HALF-1:0]};
      cout = wide[HALF];
      s_a  = sa[HALF-1];
      s_b  = b[HALF-1];
      s_r  = wide[HALF-1];
    end
    add_sv = (s_a == s_b) && (s_r != s_a);
    cvec   = sa ^ b ^ sum;
  end
endmodule

// File: rtl/shladd_unit.sv
module shladd_unit #(
  parameter int XLEN = shladd_pkg::XLEN,
  parameter int SHW  = shladd_pkg::SHW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [SHW-1:0]  shamt,
  input  logic            mode64,
  input  logic            use_carry,
  input  logic            trap_en,
  output logic [XLEN-1:0] sum_q,
  output logic            sv_q,
  output logic            uv_q,
  output logic [XLEN-1:0] cvec_q,
  output logic            trap_q
);
  import shladd_pkg::*;
  localparam int HALF = XLEN / 2;

  word_mode_e      wmode;
  logic [XLEN-1:0] a_m, b_m, sa, sum_c, cvec_c;
  logic            shift_sv, shift_lost, cout, add_sv, sv_c, uv_c, trap_c;
  logic            carry_q, cin;

  assign wmode = word_mode_e'(mode64);
  assign a_m   = (wmode == WORD64) ? op_a : {{HALF{1'b0}}, op_a[HALF-1:0]};
  assign b_m   = (wmode == WORD64) ? op_b : {{HALF{1'b0}}, op_b[HALF-1:0]};
  assign cin   = use_carry & carry_q;

  shladd_shift_ovf #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .a_m(a_m), .shamt(shamt), .mode64(mode64),
    .sa(sa), .shift_sv(shift_sv), .shift_lost(shift_lost)
  );

  shladd_adder #(.XLEN(XLEN)) u_add (
    .sa(sa), .b(b_m), .cin(cin), .mode64(mode64),
    .sum(sum_c), .cvec(cvec_c), .cout(cout), .add_sv(add_sv)
  );

  assign sv_c   = add_sv | shift_sv;
  assign uv_c   = cout | shift_lost;
  assign trap_c = trap_en & sv_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      cvec_q  <= '0;
      sv_q    <= 1'b0;
      uv_q    <= 1'b0;
      trap_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      trap_q <= in_valid & trap_c;
      if (in_valid) begin
        sv_q <= sv_c;
        uv_q <= uv_c;
        if (!trap_c) begin
          sum_q   <= sum_c;
          cvec_q  <= cvec_c;
          carry_q <= cout;
        end
      end
    end
  end

  // R9: a trap freezes the written-back result
  p_trap_holds_sum_r9: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> ($stable(sum_q) && $stable(cvec_q)));
  // R9: a trap only comes with signed overflow and an enabled trap
  p_trap_has_sv_r9: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> (sv_q && $past(trap_en)));
  // R8: nothing changes without a strobe
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_q) && $stable(sv_q) && $stable(uv_q) && !trap_q));
  // R2: 32-bit results leave the upper half clear
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode64 && !trap_en) |=> (sum_q[XLEN-1:HALF] == '0 && cvec_q[XLEN-1:HALF] == '0));
  // R5: set bits lost in a 64-bit shift always give unsigned overflow
  p_lost_bit_uv_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode64 && shamt != '0 && op_a[XLEN-1]) |=> uv_q);
endmodule

// File: tb/shladd_unit_tb.sv
module shladd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, mode64, use_carry, trap_en;
  logic [63:0] op_a, op_b;
  logic [1:0]  shamt;
  logic [63:0] sum_q, cvec_q;
  logic        sv_q, uv_q, trap_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic        m_carry;
  logic [63:0] m_sum, m_cvec;

  always #5 clk = ~clk;

  shladd_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .shamt(shamt), .mode64(mode64), .use_carry(use_carry), .trap_en(trap_en),
    .sum_q(sum_q), .sv_q(sv_q), .uv_q(uv_q), .cvec_q(cvec_q), .trap_q(trap_q)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [71:0] sext(input logic [71:0] x, input int w);
    logic [71:0] m;
    m = x & ((72'd1 << w) - 72'd1);
    if (m[w-1]) return $signed(m) - $signed(72'd1 << w);
    return $signed(m);
  endfunction

  function automatic bit fits(input logic signed [71:0] x, input int w);
    logic signed [71:0] hi, lo;
    hi = $signed((72'd1 << (w - 1)) - 72'd1);
    lo = -$signed(72'd1 << (w - 1));
    return (x <= hi) && (x >= lo);
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] k,
                        input logic m64, input logic uc, input logic te, input string tag);
    int w;
    logic [71:0] am, bm, msk, sa_t, sw, uvs;
    logic c, e_sv, e_uv, e_cout, e_trap;
    logic [63:0] e_sum, e_cvec;
    w   = m64 ? 64 : 32;
    msk = (72'd1 << w) - 72'd1;
    am  = {8'd0, a} & msk;
    bm  = {8'd0, b} & msk;
    c   = uc & m_carry;
    sa_t = (am << k) & msk;
    sw   = sa_t + bm + {71'd0, c};
    e_cout = sw[w];
    e_sum  = 64'(sw & msk);
    e_cvec = 64'(sa_t ^ bm ^ (sw & msk));
    uvs  = (am << k) + bm + {71'd0, c};
    e_uv = (uvs >> w) != 72'd0;
    e_sv = !fits(sext(am, w) <<< k, w) ||
           !fits(sext(sa_t, w) + sext(bm, w) + $signed({71'd0, c}), w);
    e_trap = te & e_sv;
    if (!e_trap) begin
      m_sum = e_sum; m_cvec = e_cvec; m_carry = e_cout;
    end
    @(negedge clk);
    op_a = a; op_b = b; shamt = k; mode64 = m64; use_carry = uc; trap_en = te; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1/R2"}, "sum", sum_q, m_sum);
    chk({tag, " R6"}, "cvec", cvec_q, m_cvec);
    chk({tag, " R3/R4"}, "sv", {63'd0, sv_q}, {63'd0, e_sv});
    chk({tag, " R5"}, "uv", {63'd0, uv_q}, {63'd0, e_uv});
    chk({tag, " R9"}, "trap", {63'd0, trap_q}, {63'd0, e_trap});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return {$urandom, $urandom};
      1: return 64'h8000_0000_0000_0000 >> ($urandom % 4);
      2: return 64'hFFFF_FFFF_FFFF_FFFF ^ (64'h1 << (59 + $urandom % 5));
      3: return {$urandom, 32'h8000_0000 >> ($urandom % 4)};
      4: return {$urandom, 32'h7FFF_FFFF ^ (32'h1 << ($urandom % 32))};
      default: return 64'(($urandom % 8));
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; in_valid = 1'b0; op_a = '1; op_b = '1; shamt = 2'd3;
    mode64 = 1'b1; use_carry = 1'b0; trap_en = 1'b0;
    m_carry = 1'b0; m_sum = '0; m_cvec = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "sum", sum_q, 64'd0);
    chk("R10", "cvec", cvec_q, 64'd0);
    chk("R10", "flags", {61'd0, sv_q, uv_q, trap_q}, 64'd0);

    // R4: shift by 1 moves bit 62 into sign, sum itself in range
    run_op(64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000, 2'd1, 1'b1, 1'b0, 1'b0, "dir R4 s1");
    // R4: shift by 3, bit 60 differs from sign
    run_op(64'h1000_0000_0000_0000, 64'd0, 2'd3, 1'b1, 1'b0, 1'b0, "dir R4 s3");
    // R3: plain add overflow, shift 0
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 2'd0, 1'b1, 1'b0, 1'b0, "dir R3");
    // R5: set top bit lost, no adder carry
    run_op(64'h8000_0000_0000_0000, 64'd0, 2'd1, 1'b1, 1'b0, 1'b0, "dir R5");
    // R2: 32-bit mode, garbage upper half, sign at bit 31
    run_op(64'hFFFF_FFFF_4000_0000, 64'hAAAA_AAAA_0000_0000, 2'd1, 1'b0, 1'b0, 1'b0, "dir R2");
    // R7: carry chain in 64-bit then 32-bit
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'd0, 1'b1, 1'b0, 1'b0, "dir R7 gen");
    run_op(64'd0, 64'd0, 2'd0, 1'b1, 1'b1, 1'b0, "dir R7 use");
    run_op(64'h0000_0000_FFFF_FFFF, 64'd1, 2'd0, 1'b0, 1'b0, 1'b0, "dir R7 gen32");
    run_op(64'd5, 64'd0, 2'd2, 1'b0, 1'b1, 1'b0, "dir R7 use32");
    // R9: trap suppresses writeback
    run_op(64'd7, 64'd9, 2'd0, 1'b1, 1'b0, 1'b0, "dir R9 pre");
    run_op(64'h2000_0000_0000_0000, 64'd3, 2'd2, 1'b1, 1'b0, 1'b1, "dir R9 trap");
    run_op(64'd0, 64'd0, 2'd0, 1'b1, 1'b1, 1'b0, "dir R9 carry held");
    // R8: idle cycle holds outputs and drops the trap pulse
    run_op(64'h4000_0000, 64'd0, 2'd1, 1'b0, 1'b0, 1'b1, "dir R8 trap");
    @(negedge clk);
    chk("R8", "trap after idle", {63'd0, trap_q}, 64'd0);
    chk("R8", "sum held", sum_q, m_sum);

    for (int n = 0; n < 3000; n++) begin
      run_op(pick(), pick(), 2'($urandom % 4), 1'($urandom % 2),
             1'($urandom % 2), 1'(($urandom % 4) == 0), "rnd");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule